// File: doc/BRIEF.md
# Vector Type Configuration Register with Tail Policy

This block holds the vector type state of a vector unit. A set-vector-length operation arrives as a one-cycle write strobe. The strobe carries three fields: an element-width code, a length-multiplier code and a 2-bit tail option. The block checks the request and stores the packed vector type word. When the request is illegal, the stored word keeps only the illegal flag. The vector length granted to the operation is computed elsewhere. Decoding the instruction is also done elsewhere.

The tail option takes one of four codes. Code 00 means "use the implementation preference". Code 01 keeps tail elements undisturbed. Code 10 zeroes them. Code 11 is reserved. A read-only preference word reports which tail behaviour the implementation prefers. A build parameter says whether zeroing is supported. A second parameter says whether zeroing is preferred. A minimal build supports undisturbed only and reports 01. The execution datapath receives a resolved tail policy. It is therefore never asked to handle the "use preference" code.

Top module: `vtcfg_reg`

## Requirements
- R1: After a synchronous active-low reset, the whole vector type word is zero. This means the tail field is 00 and the illegal flag is 0.
- R2: A legal write stores the length-multiplier code in bits 2:0, the element-width code in bits 5:3 and the tail code in bits 9:8. A tail code of 00 (no option given) is stored as 00.
- R3: A legal write with tail code 01 (undisturbed) stores 01 in bits 9:8.
- R4: Tail code 10 (zeroing) stores 10 when zeroing is supported. When zeroing is not supported, it sets the illegal flag.
- R5: Tail code 11 (reserved) always sets the illegal flag.
- R6: The illegal flag is the top bit of the vector type word (bit XLEN-1). Whenever it is set, every other bit of the word is zero.
- R7: An element-width code above MAX_SEW_CODE (default 3) sets the illegal flag. The length-multiplier code 100 (reserved) also sets it.
- R8: Bits 1:0 of the preference word read 10 when zeroing is both supported and preferred, and 01 otherwise. All other bits of the preference word are zero.
- R9: The effective tail policy equals the stored tail field when that field is 01 or 10. When the field is 00 (including after an illegal write), it equals the preference code. Either way it is always 01 or 10.
- R10: A write becomes visible on the cycle after the strobe. Without a strobe, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_sew | input | 3 | Requested element-width code |
| cfg_lmul | input | 3 | Requested length-multiplier code |
| cfg_tail | input | 2 | Requested tail option code |
| vtype_o | output | XLEN | Stored vector type word |
| vill_o | output | 1 | Illegal-configuration flag |
| tail_pref_o | output | XLEN | Read-only preference word |
| tail_eff_o | output | 2 | Resolved tail policy for the datapath |

## Verification
Some properties are checked on every cycle. The stored word must hold when there is no strobe. Every other bit must be zero whenever the illegal flag is set. The resolved policy must always be one-hot. A reserved tail code, or zeroing on a build without zeroing support, must be followed by the illegal flag. Other behaviours only the bench scenarios can show. These are the exact field positions of a legal write and the resolution of code 00 to the preference under both builds. They also include the full sweep of width, multiplier and tail codes, and the return to zero on reset in the middle of a run.

// File: rtl/vtcfg_pkg.sv
// Shared encodings for the vector type configuration register.
// Assumes the tail field sits at bits 9:8 and the illegal flag at the top bit.
package vtcfg_pkg;
    typedef enum logic [1:0] {
        TP_PREF   = 2'b00,
        TP_UNDIST = 2'b01,
        TP_ZERO   = 2'b10,
        TP_RSVD   = 2'b11
    } tail_code_e;

    localparam int LMUL_LSB = 0;
    localparam int SEW_LSB  = 3;
    localparam int TAIL_LSB = 8;
endpackage

// File: rtl/vtcfg_legal.sv
// Checks a configuration request and packs the next vector type word.
// Assumes the field widths fit below bit TAIL_LSB and that XLEN >= 12.
module vtcfg_legal
    import vtcfg_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int SEW_W        = 3,
    parameter int LMUL_W       = 3,
    parameter int MAX_SEW_CODE = 3,
    parameter bit ZERO_OK      = 1'b0
) (
    input  logic [SEW_W-1:0]  req_sew,
    input  logic [LMUL_W-1:0] req_lmul,
    input  logic [1:0]        req_tail,
    output logic [XLEN-1:0]   next_vtype
);
    localparam logic [LMUL_W-1:0] LMUL_RSVD = LMUL_W'(1) << (LMUL_W - 1);
    localparam int                ILL_BIT   = XLEN - 1;

    logic tail_bad;
    logic sew_bad;
    logic lmul_bad;
    logic illegal;

    // Decide whether any requested field is unsupported or reserved.
    always_comb begin
        tail_bad = (req_tail == TP_RSVD) || ((req_tail == TP_ZERO) && !ZERO_OK);
        sew_bad  = (int'(req_sew) > MAX_SEW_CODE);
        lmul_bad = (req_lmul == LMUL_RSVD);
        illegal  = tail_bad || sew_bad || lmul_bad;
    end

    // Pack the legal fields, or leave only the illegal flag.
    always_comb begin
        next_vtype = '0;
        if (illegal) begin
            next_vtype[ILL_BIT] = 1'b1;
        end else begin
            next_vtype[LMUL_LSB +: LMUL_W] = req_lmul;
            next_vtype[SEW_LSB  +: SEW_W]  = req_sew;
            next_vtype[TAIL_LSB +: 2]      = req_tail;
        end
    end
endmodule

// File: rtl/vtcfg_pref.sv
// Builds the read-only preference word and resolves the stored tail code.
// Assumes that zeroing is only preferred when it is supported.
module vtcfg_pref
    import vtcfg_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit ZERO_OK     = 1'b0,
    parameter bit PREFER_ZERO = 1'b0
) (
    input  logic [1:0]      tail_field,
    output logic [XLEN-1:0] pref_word,
    output logic [1:0]      tail_eff
);
    localparam logic [1:0] PREF_CODE = (ZERO_OK && PREFER_ZERO) ? TP_ZERO : TP_UNDIST;

    // Place the constant preference code in the low bits of the word.
    always_comb begin
        pref_word       = '0;
        pref_word[1:0]  = PREF_CODE;
    end

    // Replace the "use preference" code (and any other code) with a concrete policy.
    always_comb begin
        unique case (tail_field)
            TP_UNDIST: tail_eff = TP_UNDIST;
            TP_ZERO:   tail_eff = TP_ZERO;
            default:   tail_eff = PREF_CODE;
        endcase
    end
endmodule

// File: rtl/vtcfg_reg.sv
// Top of the vector type configuration register.
// A one-cycle strobe loads a checked and packed word, which is visible on the next cycle.
// Assumes a synchronous active-low reset and strobes issued one at a time.
module vtcfg_reg
    import vtcfg_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int MAX_SEW_CODE = 3,
    parameter bit ZERO_OK      = 1'b0,
    parameter bit PREFER_ZERO  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sew,
    input  logic [2:0]      cfg_lmul,
    input  logic [1:0]      cfg_tail,
    output logic [XLEN-1:0] vtype_o,
    output logic            vill_o,
    output logic [XLEN-1:0] tail_pref_o,
    output logic [1:0]      tail_eff_o
);
    localparam int ILL_BIT = XLEN - 1;

    logic [XLEN-1:0] next_vtype;
    logic [XLEN-1:0] vtype_q;

    vtcfg_legal #(
        .XLEN(XLEN), .SEW_W(3), .LMUL_W(3),
        .MAX_SEW_CODE(MAX_SEW_CODE), .ZERO_OK(ZERO_OK)
    ) u_legal (
        .req_sew(cfg_sew), .req_lmul(cfg_lmul), .req_tail(cfg_tail),
        .next_vtype(next_vtype)
    );

    // Hold the architectural word; load it on a strobe; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      vtype_q <= '0;
        else if (cfg_we) vtype_q <= next_vtype;
    end

    vtcfg_pref #(
        .XLEN(XLEN), .ZERO_OK(ZERO_OK), .PREFER_ZERO(PREFER_ZERO)
    ) u_pref (
        .tail_field(vtype_q[TAIL_LSB +: 2]),
        .pref_word(tail_pref_o),
        .tail_eff(tail_eff_o)
    );

    assign vtype_o = vtype_q;
    assign vill_o  = vtype_q[ILL_BIT];

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(vtype_o));
    p_vill_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vill_o |-> (vtype_o[XLEN-2:0] == '0));
    p_eff_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tail_eff_o));
    p_rsvd_ill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_tail == TP_RSVD) |=> vill_o);
    p_undist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_tail == TP_UNDIST) |=> (vill_o || vtype_o[TAIL_LSB +: 2] == TP_UNDIST));

    generate
        if (!ZERO_OK) begin : g_nozero
            p_nozero_ill_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_tail == TP_ZERO) |=> vill_o);
        end
    endgenerate
endmodule

// File: tb/vtcfg_reg_tb.sv
module vtcfg_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sew = '0;
    logic [2:0] cfg_lmul = '0;
    logic [1:0] cfg_tail = '0;

    logic [XLEN-1:0] vt0, pref0, vt1, pref1;
    logic ill0, ill1;
    logic [1:0] eff0, eff1;

    int tests = 0;
    int fails = 0;
    int unsigned mdl0 = 0;
    int unsigned mdl1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Minimal build: no zeroing support.
    vtcfg_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sew(cfg_sew),
        .cfg_lmul(cfg_lmul), .cfg_tail(cfg_tail), .vtype_o(vt0),
        .vill_o(ill0), .tail_pref_o(pref0), .tail_eff_o(eff0)
    );

    // Build with zeroing supported and preferred.
    vtcfg_reg #(.ZERO_OK(1'b1), .PREFER_ZERO(1'b1)) u_dut_z (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sew(cfg_sew),
        .cfg_lmul(cfg_lmul), .cfg_tail(cfg_tail), .vtype_o(vt1),
        .vill_o(ill1), .tail_pref_o(pref1), .tail_eff_o(eff1)
    );

    function automatic int unsigned expect_word(int s, int l, int t, bit zs);
        bit bad;
        bad = (t == 3) || (t == 2 && !zs) || (s > 3) || (l == 4);
        if (bad) return 32'h8000_0000;
        return (t * 256) + (s * 8) + l;
    endfunction

    task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int unsigned p0, p1, f0, f1;
        p0 = 1; p1 = 2;
        f0 = (mdl0 / 256) % 4; f1 = (mdl1 / 256) % 4;
        chk(tag, "vtype minimal", vt0, mdl0);
        chk(tag, "vtype zeroing", vt1, mdl1);
        chk("R6", "vill minimal", ill0, mdl0 / 32'h8000_0000);
        chk("R6", "vill zeroing", ill1, mdl1 / 32'h8000_0000);
        chk("R8", "pref minimal", pref0, p0);
        chk("R8", "pref zeroing", pref1, p1);
        chk("R9", "eff minimal", eff0, (f0 == 0) ? p0 : f0);
        chk("R9", "eff zeroing", eff1, (f1 == 0) ? p1 : f1);
    endtask

    task automatic step(string tag, bit we, int s, int l, int t, bit rst);
        cfg_we = we; cfg_sew = 3'(s); cfg_lmul = 3'(l); cfg_tail = 2'(t);
        rst_n = ~rst;
        @(posedge clk);
        if (rst) begin
            mdl0 = 0; mdl1 = 0;
        end else if (we) begin
            mdl0 = expect_word(s, l, t, 1'b0);
            mdl1 = expect_word(s, l, t, 1'b1);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        step("R1", 0, 0, 0, 0, 1);
        step("R1", 0, 0, 0, 0, 1);
        step("R2", 1, 2, 1, 0, 0);
        step("R3", 1, 3, 2, 1, 0);
        step("R10", 0, 1, 1, 2, 0);
        step("R4", 1, 1, 0, 2, 0);
        step("R10", 0, 0, 0, 3, 0);
        step("R5", 1, 0, 0, 3, 0);
        step("R7", 1, 5, 0, 1, 0);
        step("R7", 1, 0, 4, 1, 0);
        step("R2", 1, 3, 7, 0, 0);
        step("R6", 1, 7, 4, 3, 0);
        step("R10", 0, 2, 2, 1, 0);
        for (int s = 0; s < 8; s++)
            for (int l = 0; l < 8; l++)
                for (int t = 0; t < 4; t++)
                    step("R2", 1, s, l, t, 0);
        step("R3", 1, 1, 1, 1, 0);
        step("R1", 0, 0, 0, 0, 1);
        step("R10", 0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule